// File: doc/BRIEF.md
# Interrupt Destination Match

This block decides whether one local interrupt controller is among the targets of an incoming interrupt message. It holds three pieces of state: the controller's own ID, a logical destination register and a destination format register. For each message it looks at the destination field, the addressing mode (physical or logical), a two-bit shorthand and a flag that says whether the message came from this controller. From these it produces a single match bit. The decision is combinational on the stored state and the message inputs. Only the register writes take a clock cycle.

Logical addressing comes in two formats. In the flat format, each bit of the 8-bit logical ID stands for one group. In the cluster format, the upper nibble names a cluster and the lower nibble selects members inside it. A separate extended mode widens logical matching to the full 32-bit logical register. In that mode the register is rebuilt from the local ID on every clock, and software writes to the ID, logical and format registers are ignored. Message transport and arbitration between controllers are handled elsewhere.

Top module: `destmatch_top`

## Requirements
- R1: After a synchronous active-low reset, the ID reads 0x00, the logical register reads 0x00000000 and the format register reads 0xFFFFFFFF.
- R2: With shorthand 0 and physical mode, the match bit is high exactly when the low 8 bits of the destination are 0xFF or equal the ID. Destination bits above bit 7 are ignored.
- R3: With shorthand 0, logical mode, extended mode off and format nibble (bits 31:28 of the format register) equal to 0xF, the block matches when the logical ID ANDed with destination bits 7:0 is nonzero. The logical ID is bits 31:24 of the logical register.
- R4: Under the same conditions but with format nibble 0x0, the block matches when logical ID bits 7:4 equal destination bits 7:4 and the AND of logical ID bits 3:0 with destination bits 3:0 is nonzero.
- R5: In extended mode, a logical-mode message with shorthand 0 matches when the full 32-bit logical register ANDed with the 32-bit destination is nonzero.
- R6: Shorthand 1 matches only when the source-is-self flag is high. Shorthand 2 always matches. Shorthand 3 matches only when the flag is low. The destination and mode inputs are ignored for shorthands 1, 2 and 3.
- R7: While extended mode is high, the logical register becomes ((id & 0xF0) << 16) | (1 << (id & 0xF)) at each clock edge, so the new value can be read one cycle after extended mode rises.
- R8: A write to the format register (select 2) stores data bits 31:28 and forces bits 27:0 to ones. Writes to the ID (select 0) and the logical register (select 1) store the data, and each write takes effect at the next clock edge.
- R9: A logical-mode message with shorthand 0, extended mode off and a format nibble other than 0xF or 0x0 gives no match and raises the format error output. The error output is low in every other case.
- R10: While extended mode is high, writes to the ID, the logical register and the format register leave their read-back values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 ID, 1 logical register, 2 format register, 3 none |
| wr_data_i | input | 32 | Write data |
| ext_mode_i | input | 1 | Extended addressing mode |
| dest_i | input | 32 | Destination field of the message |
| dest_logical_i | input | 1 | 1 for logical addressing, 0 for physical addressing |
| shorthand_i | input | 2 | 0 destination field, 1 self, 2 all, 3 all but self |
| src_self_i | input | 1 | The message was sent by this controller |
| match_o | output | 1 | This controller is a target |
| fmt_err_o | output | 1 | The logical lookup met an unsupported format |
| id_o | output | 8 | Current local ID |
| ldr_o | output | 32 | Current logical destination register |
| dfr_o | output | 32 | Current format register |

## Verification
The bench sweeps all 256 destination bytes against several IDs and logical IDs. A design that left out the broadcast value, compared the wrong nibble in cluster format, or used OR where AND belongs would show a mismatch somewhere in those sweeps. It also rebuilds the extended logical register for every possible ID, which catches a wrong shift amount or a one-hot built from the wrong nibble. The bench also checks the cases where inputs are ignored: shorthands that must disregard the destination and mode, physical addresses with the upper bits set, and register writes made while extended mode is high. A design that let any of these through would change the match bit or a read-back value.

// File: rtl/destmatch_pkg.sv
// Shared encodings for the destination match block.
// Assumes a 4-bit format code held in the top nibble of the format register.
package destmatch_pkg;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [1:0] {
        RSEL_ID   = 2'd0,
        RSEL_LDR  = 2'd1,
        RSEL_DFR  = 2'd2,
        RSEL_NONE = 2'd3
    } regsel_e;

    localparam int FMT_W = 4;
    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

endpackage

// File: rtl/destmatch_regs.sv
// Register store for the local ID, the logical destination register and the
// format register. In extended mode the logical register is rebuilt from the
// ID each cycle and all writes are dropped.
// Assumes ID_W is even and REG_W >= ID_W + REG_W/2.
module destmatch_regs
    import destmatch_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             ext_mode_i,
    output logic [ID_W-1:0]  id_o,
    output logic [REG_W-1:0] ldr_o,
    output logic [REG_W-1:0] dfr_o
);

    localparam int NIB        = ID_W / 2;
    localparam int CLUS_SHIFT = REG_W / 2;
    localparam int FMT_KEEP   = REG_W - FMT_W;

    logic [ID_W-1:0]  id_q;
    logic [REG_W-1:0] ldr_q;
    logic [REG_W-1:0] dfr_q;
    logic [REG_W-1:0] ext_ldr;
    regsel_e          sel;

    assign sel = regsel_e'(wr_sel_i);

    // Build the extended-mode logical value: cluster bits shifted up, member one-hot below
    always_comb begin
        ext_ldr = (REG_W'(id_q) & ~REG_W'({NIB{1'b1}})) << CLUS_SHIFT;
        ext_ldr = ext_ldr | (REG_W'(1) << id_q[NIB-1:0]);
    end

    // Register updates: reset, extended-mode rebuild, or software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            ldr_q <= '0;
            dfr_q <= '1;
        end else if (ext_mode_i) begin
            ldr_q <= ext_ldr;
        end else if (wr_en_i) begin
            case (sel)
                RSEL_ID:  id_q  <= wr_data_i[ID_W-1:0];
                RSEL_LDR: ldr_q <= wr_data_i;
                RSEL_DFR: dfr_q <= {wr_data_i[REG_W-1 -: FMT_W], {FMT_KEEP{1'b1}}};
                default:  ;
            endcase
        end
    end

    assign id_o  = id_q;
    assign ldr_o = ldr_q;
    assign dfr_o = dfr_q;

    AST_DFR_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (&dfr_q[FMT_KEEP-1:0])); // R8

    AST_EXT_LDR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode_i && $past(ext_mode_i) && $past(rst_n))
        |-> ($countones(ldr_q[CLUS_SHIFT-1:0]) == 1)); // R7

    AST_EXT_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_mode_i) && $past(rst_n)) |-> ($stable(id_q) && $stable(dfr_q))); // R10

endmodule

// File: rtl/destmatch_logical.sv
// Logical-address comparator: flat, cluster or extended matching against the
// stored logical register. Purely combinational.
// Assumes the format code arrives as the top nibble of the format register.
module destmatch_logical
    import destmatch_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int REG_W = 32
) (
    input  logic [REG_W-1:0] ldr_i,
    input  logic [FMT_W-1:0] fmt_i,
    input  logic [REG_W-1:0] dest_i,
    input  logic             ext_mode_i,
    output logic             hit_o,
    output logic             fmt_err_o
);

    localparam int NIB = ID_W / 2;

    logic [ID_W-1:0] lid;
    logic [ID_W-1:0] dbyte;

    assign lid   = ldr_i[REG_W-1 -: ID_W];
    assign dbyte = dest_i[ID_W-1:0];

    // Select the comparison rule from the mode and format code
    always_comb begin
        hit_o     = 1'b0;
        fmt_err_o = 1'b0;
        if (ext_mode_i) begin
            hit_o = |(ldr_i & dest_i);
        end else begin
            case (fmt_i)
                FMT_FLAT:    hit_o = |(lid & dbyte);
                FMT_CLUSTER: hit_o = (lid[ID_W-1 -: NIB] == dbyte[ID_W-1 -: NIB])
                                     && |(lid[NIB-1:0] & dbyte[NIB-1:0]);
                default:     fmt_err_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/destmatch_top.sv
// Destination match decision for one local interrupt controller. Combines the
// shorthand, physical and logical paths into a single match bit.
// Assumes message inputs are stable around the sampling edge; only the
// register writes are clocked.
module destmatch_top
    import destmatch_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             ext_mode_i,
    input  logic [REG_W-1:0] dest_i,
    input  logic             dest_logical_i,
    input  logic [1:0]       shorthand_i,
    input  logic             src_self_i,
    output logic             match_o,
    output logic             fmt_err_o,
    output logic [ID_W-1:0]  id_o,
    output logic [REG_W-1:0] ldr_o,
    output logic [REG_W-1:0] dfr_o
);

    localparam logic [ID_W-1:0] BCAST = '1;

    logic       log_hit;
    logic       log_err;
    logic       phys_hit;
    shorthand_e sh;

    assign sh = shorthand_e'(shorthand_i);

    destmatch_regs #(.ID_W(ID_W), .REG_W(REG_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .ext_mode_i (ext_mode_i),
        .id_o       (id_o),
        .ldr_o      (ldr_o),
        .dfr_o      (dfr_o)
    );

    destmatch_logical #(.ID_W(ID_W), .REG_W(REG_W)) logical_i (
        .ldr_i      (ldr_o),
        .fmt_i      (dfr_o[REG_W-1 -: FMT_W]),
        .dest_i     (dest_i),
        .ext_mode_i (ext_mode_i),
        .hit_o      (log_hit),
        .fmt_err_o  (log_err)
    );

    // Physical compare against broadcast and the local ID
    assign phys_hit = (dest_i[ID_W-1:0] == BCAST) || (dest_i[ID_W-1:0] == id_o);

    // Shorthand decode picks the final decision
    always_comb begin
        case (sh)
            SH_NONE:   match_o = dest_logical_i ? log_hit : phys_hit;
            SH_SELF:   match_o = src_self_i;
            SH_ALL:    match_o = 1'b1;
            SH_OTHERS: match_o = !src_self_i;
            default:   match_o = 1'b0;
        endcase
    end

    // Error only when the logical path actually decided
    assign fmt_err_o = (sh == SH_NONE) && dest_logical_i && log_err;

    AST_SHORT_ALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand_i == 2'd2) |-> match_o); // R6

    AST_SHORT_OTHERS_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand_i == 2'd3 && src_self_i) |-> !match_o); // R6

    AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand_i == 2'd0 && !dest_logical_i && dest_i[ID_W-1:0] == BCAST)
        |-> match_o); // R2

    AST_FMT_ERR_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |-> !match_o); // R9

endmodule

// File: tb/destmatch_top_tb.sv
`timescale 1ns/1ps
module destmatch_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic        ext_mode = 1'b0;
    logic [31:0] dest = '0;
    logic        dest_logical = 1'b0;
    logic [1:0]  shorthand = 2'd0;
    logic        src_self = 1'b0;
    logic        match;
    logic        fmt_err;
    logic [7:0]  id;
    logic [31:0] ldr;
    logic [31:0] dfr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    destmatch_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .ext_mode_i(ext_mode), .dest_i(dest),
        .dest_logical_i(dest_logical), .shorthand_i(shorthand),
        .src_self_i(src_self), .match_o(match), .fmt_err_o(fmt_err),
        .id_o(id), .ldr_o(ldr), .dfr_o(dfr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic probe(input logic [1:0] sh, input logic lg, input logic sf, input logic [31:0] d);
        shorthand = sh; dest_logical = lg; src_self = sf; dest = d;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0]  ids [3];
        logic [7:0]  fl  [3];
        logic [7:0]  cl  [3];
        logic [31:0] e;
        ids = '{8'h00, 8'h5A, 8'hFE};
        fl  = '{8'h01, 8'h80, 8'hA5};
        cl  = '{8'h31, 8'h3F, 8'hF8};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 id", {24'h0, id}, 32'h0);
        chk("R1 ldr", ldr, 32'h0);
        chk("R1 dfr", dfr, 32'hFFFF_FFFF);

        // R2 physical sweep
        for (int k = 0; k < 3; k++) begin
            wr(2'd0, {24'h0, ids[k]});
            chk("R8 id write", {24'h0, id}, {24'h0, ids[k]});
            for (int d = 0; d < 256; d++) begin
                probe(2'd0, 1'b0, 1'b0, 32'(d));
                chk("R2 phys", {31'h0, match}, {31'h0, (d == 255) || (d == int'(ids[k]))});
            end
            probe(2'd0, 1'b0, 1'b0, 32'hABCD_0000 | {24'h0, ids[k]});
            chk("R2 upper ignored", {31'h0, match}, 32'h1);
        end

        // R3 flat sweep
        wr(2'd2, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) begin
            wr(2'd1, {fl[k], 24'h0});
            chk("R8 ldr write", ldr, {fl[k], 24'h0});
            for (int d = 0; d < 256; d++) begin
                probe(2'd0, 1'b1, 1'b0, 32'(d));
                chk("R3 flat", {31'h0, match}, {31'h0, (fl[k] & 8'(d)) != 0});
                chk("R9 no err flat", {31'h0, fmt_err}, 32'h0);
            end
        end

        // R4 cluster sweep
        wr(2'd2, 32'h0);
        chk("R8 dfr forced ones", dfr, 32'h0FFF_FFFF);
        for (int k = 0; k < 3; k++) begin
            wr(2'd1, {cl[k], 24'h0});
            for (int d = 0; d < 256; d++) begin
                probe(2'd0, 1'b1, 1'b0, 32'(d));
                chk("R4 cluster", {31'h0, match},
                    {31'h0, (cl[k][7:4] == 4'(d >> 4)) && ((cl[k][3:0] & 4'(d)) != 0)});
            end
        end

        // R9 unsupported format
        wr(2'd2, 32'h5123_4567);
        chk("R8 dfr value", dfr, 32'h5FFF_FFFF);
        probe(2'd0, 1'b1, 1'b0, 32'hFF);
        chk("R9 match", {31'h0, match}, 32'h0);
        chk("R9 err", {31'h0, fmt_err}, 32'h1);
        probe(2'd0, 1'b0, 1'b0, 32'hFF);
        chk("R9 err phys", {31'h0, fmt_err}, 32'h0);
        probe(2'd2, 1'b1, 1'b0, 32'h00);
        chk("R9 err shorthand", {31'h0, fmt_err}, 32'h0);
        wr(2'd2, 32'hF000_0000);

        // R6 shorthands
        wr(2'd0, 32'h12);
        for (int s = 1; s < 4; s++)
            for (int f = 0; f < 2; f++)
                for (int m = 0; m < 2; m++) begin
                    probe(2'(s), 1'(m), 1'(f), 32'h34);
                    e = (s == 1) ? 32'(f) : (s == 2) ? 32'h1 : 32'(1 - f);
                    chk("R6 shorthand", {31'h0, match}, e);
                end

        // R7 / R5 extended derivation for every ID
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, 32'(v));
            ext_mode = 1'b1;
            @(posedge clk); @(negedge clk);
            e = ((32'(v) & 32'hF0) << 16) | (32'h1 << (v & 15));
            chk("R7 ext ldr", ldr, e);
            if (v % 37 == 0)
                for (int b = 0; b < 32; b++) begin
                    probe(2'd0, 1'b1, 1'b0, 32'h1 << b);
                    chk("R5 ext match", {31'h0, match}, {31'h0, (e & (32'h1 << b)) != 0});
                end
            ext_mode = 1'b0;
        end

        // R10 writes ignored in extended mode
        wr(2'd0, 32'h47);
        ext_mode = 1'b1;
        @(posedge clk);
        wr(2'd0, 32'h99);
        chk("R10 id held", {24'h0, id}, 32'h47);
        wr(2'd1, 32'h1234_5678);
        chk("R10 ldr held", ldr, 32'h0040_0080);
        wr(2'd2, 32'h0);
        chk("R10 dfr held", dfr, 32'hFFFF_FFFF);
        probe(2'd0, 1'b1, 1'b0, 32'h0040_0000);
        chk("R5 ext cluster bit", {31'h0, match}, 32'h1);
        probe(2'd0, 1'b1, 1'b0, 32'h0000_0040);
        chk("R5 ext miss", {31'h0, match}, 32'h0);
        ext_mode = 1'b0;

        done = 1'b1;
        summary();
    end

endmodule